// File: doc/BRIEF.md
# Regulator Rail Fault Supervisor

This block is the digital supervisor that sits behind the protection comparators of one regulator rail. It watches two over-current flags, a relative over-voltage flag, an absolute over-voltage flag and an under-voltage flag. It applies persistence timing and blanking to these flags, latches the shutdown faults, stops switching, commands a controlled reference ramp-down after an over-voltage, and drives the rail's ready signal.

A latched shutdown stays in force until the rail's enable or its supply-good input drops. Under-voltage is treated differently: it only withdraws ready while the condition lasts. The block also holds the programmable under-voltage margin that feeds the threshold generator. It scales the current-limit thresholds by the full-power phase count whenever the rail runs in a low power state.

Top module: `rail_fault_mgr`

## Requirements
- R1: While `en` or `supply_ok` is low, `pwm_off`=1, `rdy`=0, `dac_ramp_dn`=0 and `fault_code`=0, and every latch and timer is cleared at the next clock edge.
- R2: `ocp_slow` high for `T_OCP_SLOW` consecutive clock edges latches an over-current shutdown, with `pwm_off` going high right after the last of those edges. A low cycle restarts the count.
- R3: `ocp_fast` high for `T_OCP_FAST` consecutive clock edges latches an over-current shutdown in the same way.
- R4: While `soft_start`=1 only `ov_abs` is a valid over-voltage source. Otherwise only `ov_rel` is valid. The unselected flag has no effect.
- R5: A valid over-voltage flag latches a shutdown at the next edge, setting both `pwm_off` and `dac_ramp_dn`. `dac_ramp_dn` is never set by over-current.
- R6: `rdy` falls exactly `T_RDY_FALL` clock edges after the edge that latched an over-current or over-voltage shutdown.
- R7: A latched shutdown persists after the fault flag clears, until `en` or `supply_ok` goes low.
- R8: `uv` high for `T_UV_BLANK` consecutive edges outside soft-start drops `rdy`. `rdy` returns one edge after `uv` clears. `pwm_off` and `fault_code` are unaffected.
- R9: `fault_code` records the first latched fault (0 none, 1 delayed over-current, 2 fast over-current, 3 over-voltage). It keeps that value while later faults latch, and is cleared as in R1.
- R10: `rdy` is high exactly when the rail is enabled with good supply, not in soft-start, without an under-voltage trip, and the ready-fall delay of R6 has not expired.
- R11: `ilim_div` equals 1 when `low_power`=0 and equals `phase_cnt` when `low_power`=1.
- R12: `uv_margin` resets to `UVM_RST` (300). It takes `uvm_din` at an edge with `uvm_we`=1 and is not changed by enable or supply cycling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Rail enable |
| supply_ok | input | 1 | Supply-good indication |
| soft_start | input | 1 | Reference is in its start-up ramp |
| low_power | input | 1 | Rail runs in a reduced-phase power state |
| phase_cnt | input | PH_W | Full-power phase count |
| ocp_slow | input | 1 | Current above the 100% limit |
| ocp_fast | input | 1 | Current above the 150% limit |
| ov_rel | input | 1 | Output above reference plus margin |
| ov_abs | input | 1 | Output above the fixed start-up limit |
| uv | input | 1 | Output below reference minus droop minus margin |
| uvm_we | input | 1 | Under-voltage margin write strobe |
| uvm_din | input | UVM_W | Under-voltage margin write data |
| pwm_off | output | 1 | Force all phase PWMs low |
| dac_ramp_dn | output | 1 | Ramp the reference down to zero |
| rdy | output | 1 | Rail ready |
| fault_code | output | 2 | First latched fault |
| ilim_div | output | PH_W | Divider for the current-limit thresholds |
| uv_margin | output | UVM_W | Under-voltage margin to the threshold generator |

## Verification
On every cycle the assertions check four things: an over-voltage flag always stops switching at the next edge, a latched shutdown and its fault code hold while the rail stays enabled, dropping enable or supply clears the code, and soft-start keeps ready low. The persistence windows, the ready-fall delay, the choice of over-voltage source and the first-fault ordering depend on counts and on stimulus history. These are shown only by the bench's scenarios, which probe each timer one edge before and at its expiry.

// File: rtl/rail_fault_mgr.sv
module rail_fault_mgr #(
  parameter int T_OCP_SLOW = 6250,
  parameter int T_OCP_FAST = 37,
  parameter int T_UV_BLANK = 625000,
  parameter int T_RDY_FALL = 37,
  parameter int PH_W       = 3,
  parameter int UVM_W      = 10,
  parameter int UVM_RST    = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             supply_ok,
  input  logic             soft_start,
  input  logic             low_power,
  input  logic [PH_W-1:0]  phase_cnt,
  input  logic             ocp_slow,
  input  logic             ocp_fast,
  input  logic             ov_rel,
  input  logic             ov_abs,
  input  logic             uv,
  input  logic             uvm_we,
  input  logic [UVM_W-1:0] uvm_din,
  output logic             pwm_off,
  output logic             dac_ramp_dn,
  output logic             rdy,
  output logic [1:0]       fault_code,
  output logic [PH_W-1:0]  ilim_div,
  output logic [UVM_W-1:0] uv_margin
);

  localparam int SW = $clog2(T_OCP_SLOW + 1);
  localparam int FW = $clog2(T_OCP_FAST + 1);
  localparam int UW = $clog2(T_UV_BLANK + 1);
  localparam int RW = $clog2(T_RDY_FALL + 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(T_OCP_SLOW - 1);
  localparam logic [FW-1:0] FAST_LAST = FW'(T_OCP_FAST - 1);
  localparam logic [UW-1:0] UV_LAST   = UW'(T_UV_BLANK - 1);
  localparam logic [RW-1:0] RDY_LAST  = RW'(T_RDY_FALL - 1);

  logic [SW-1:0] slow_cnt;
  logic [FW-1:0] fast_cnt;
  logic [UW-1:0] uv_cnt;
  logic [RW-1:0] rdy_cnt;
  logic          ocp_lat, ovp_lat, rdy_kill, uv_trip;
  logic [1:0]    code_q;

  wire active    = en & supply_ok;
  wire slow_trip = ocp_slow & (slow_cnt == SLOW_LAST);
  wire fast_trip = ocp_fast & (fast_cnt == FAST_LAST);
  wire ovp_hit   = soft_start ? ov_abs : ov_rel;
  wire uv_live   = uv & ~soft_start;
  wire fault     = ocp_lat | ovp_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_cnt <= '0;
      fast_cnt <= '0;
      ocp_lat  <= 1'b0;
      ovp_lat  <= 1'b0;
      code_q   <= 2'd0;
    end else if (!active) begin
      slow_cnt <= '0;
      fast_cnt <= '0;
      ocp_lat  <= 1'b0;
      ovp_lat  <= 1'b0;
      code_q   <= 2'd0;
    end else begin
      if (!ocp_slow)                slow_cnt <= '0;
      else if (slow_cnt != SLOW_LAST) slow_cnt <= slow_cnt + 1'b1;
      if (!ocp_fast)                fast_cnt <= '0;
      else if (fast_cnt != FAST_LAST) fast_cnt <= fast_cnt + 1'b1;
      ocp_lat <= ocp_lat | slow_trip | fast_trip;
      ovp_lat <= ovp_lat | ovp_hit;
      if (code_q == 2'd0) begin
        if (ovp_hit)        code_q <= 2'd3;
        else if (fast_trip) code_q <= 2'd2;
        else if (slow_trip) code_q <= 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_cnt  <= '0;
      rdy_kill <= 1'b0;
    end else if (!active) begin
      rdy_cnt  <= '0;
      rdy_kill <= 1'b0;
    end else if (fault && !rdy_kill) begin
      if (rdy_cnt == RDY_LAST) rdy_kill <= 1'b1;
      else                     rdy_cnt  <= rdy_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_cnt  <= '0;
      uv_trip <= 1'b0;
    end else if (!active || !uv_live) begin
      uv_cnt  <= '0;
      uv_trip <= 1'b0;
    end else begin
      if (uv_cnt != UV_LAST) uv_cnt <= uv_cnt + 1'b1;
      if (uv_cnt == UV_LAST) uv_trip <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      uv_margin <= UVM_W'(UVM_RST);
    else if (uvm_we) uv_margin <= uvm_din;
  end

  assign pwm_off     = ~active | fault;
  assign dac_ramp_dn = active & ovp_lat;
  assign rdy         = active & ~soft_start & ~uv_trip & ~rdy_kill;
  assign fault_code  = code_q;
  assign ilim_div    = low_power ? phase_cnt : PH_W'(1);

endmodule

// File: rtl/rail_fault_mgr_chk.sv
module rail_fault_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       supply_ok,
  input logic       soft_start,
  input logic       ov_rel,
  input logic       ov_abs,
  input logic       pwm_off,
  input logic       rdy,
  input logic [1:0] fault_code
);

  p_ovp_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && supply_ok && !soft_start && ov_rel) |=> pwm_off);

  p_ovp_abs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && supply_ok && soft_start && ov_abs) |=> pwm_off);

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwm_off) && $past(en && supply_ok) && en && supply_ok) |-> pwm_off);

  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_code) != 2'd0 && $past(en && supply_ok) && en && supply_ok)
      |-> fault_code == $past(fault_code));

  p_code_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && supply_ok) |=> fault_code == 2'd0);

  p_ss_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start |-> !rdy);

endmodule

bind rail_fault_mgr rail_fault_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .supply_ok(supply_ok),
  .soft_start(soft_start), .ov_rel(ov_rel), .ov_abs(ov_abs),
  .pwm_off(pwm_off), .rdy(rdy), .fault_code(fault_code)
);

// File: tb/rail_fault_mgr_tb.sv
module rail_fault_mgr_tb;
  localparam int TS = 20, TF = 4, TU = 30, TR = 5;

  logic clk = 0, rst_n = 0;
  logic en = 0, supply_ok = 0, soft_start = 0, low_power = 0;
  logic [2:0] phase_cnt = 3'd3;
  logic ocp_slow = 0, ocp_fast = 0, ov_rel = 0, ov_abs = 0, uv = 0, uvm_we = 0;
  logic [9:0] uvm_din = '0;
  logic pwm_off, dac_ramp_dn, rdy;
  logic [1:0] fault_code;
  logic [2:0] ilim_div;
  logic [9:0] uv_margin;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rail_fault_mgr #(.T_OCP_SLOW(TS), .T_OCP_FAST(TF), .T_UV_BLANK(TU), .T_RDY_FALL(TR)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .supply_ok(supply_ok), .soft_start(soft_start),
    .low_power(low_power), .phase_cnt(phase_cnt), .ocp_slow(ocp_slow), .ocp_fast(ocp_fast),
    .ov_rel(ov_rel), .ov_abs(ov_abs), .uv(uv), .uvm_we(uvm_we), .uvm_din(uvm_din),
    .pwm_off(pwm_off), .dac_ramp_dn(dac_ramp_dn), .rdy(rdy), .fault_code(fault_code),
    .ilim_div(ilim_div), .uv_margin(uv_margin));

  // {req, en sok ss ocs ocf ovr ova uv, hold, off rdy dn code}
  localparam int NV = 23;
  localparam logic [24:0] VEC [NV] = '{
    {4'd10, 8'b11100000, 8'd3,  5'b00000}, // R10 soft-start holds ready low
    {4'd4,  8'b11100100, 8'd3,  5'b00000}, // R4 relative flag ignored in soft-start
    {4'd10, 8'b11000000, 8'd3,  5'b01000}, // R10 ready after soft-start
    {4'd8,  8'b11000001, 8'd10, 5'b01000}, // R8 under-voltage within blanking
    {4'd8,  8'b11000001, 8'd25, 5'b00000}, // R8 blanking expired, ready only
    {4'd8,  8'b11000000, 8'd2,  5'b01000}, // R8 ready returns
    {4'd2,  8'b11010000, 8'd10, 5'b01000}, // R2 short slow flag
    {4'd2,  8'b11000000, 8'd2,  5'b01000}, // R2 interruption
    {4'd2,  8'b11010000, 8'd10, 5'b01000}, // R2 count restarted
    {4'd3,  8'b11001000, 8'd10, 5'b10010}, // R3 fast over-current latch
    {4'd9,  8'b11000100, 8'd3,  5'b10110}, // R9 later OVP keeps first code
    {4'd1,  8'b01000000, 8'd2,  5'b10000}, // R1 enable low clears
    {4'd7,  8'b11000000, 8'd2,  5'b01000}, // R7 released by enable cycle
    {4'd5,  8'b11000100, 8'd8,  5'b10111}, // R5 relative OVP
    {4'd1,  8'b10000000, 8'd2,  5'b10000}, // R1 supply loss clears
    {4'd7,  8'b11000000, 8'd2,  5'b01000}, // R7 released by supply cycle
    {4'd2,  8'b11010000, 8'd30, 5'b10001}, // R2 slow over-current latch
    {4'd1,  8'b01000000, 8'd2,  5'b10000}, // R1 clear
    {4'd4,  8'b11100010, 8'd8,  5'b10111}, // R4 absolute OVP in soft-start
    {4'd1,  8'b01000000, 8'd2,  5'b10000}, // R1 clear
    {4'd4,  8'b11000010, 8'd5,  5'b01000}, // R4 absolute flag ignored after soft-start
    {4'd9,  8'b11011000, 8'd10, 5'b10010}, // R9 fast latches first
    {4'd1,  8'b01000000, 8'd2,  5'b10000}  // R1 clear
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reenable();
    en = 0; ocp_slow = 0; ocp_fast = 0; ov_rel = 0; ov_abs = 0; uv = 0; soft_start = 0;
    tick(2);
    en = 1; supply_ok = 1;
    tick(2);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1", "pwm_off in reset", pwm_off, 1);
    chk("R1", "rdy in reset", rdy, 0);
    chk("R1", "code in reset", fault_code, 0);
    chk("R12", "margin reset", uv_margin, 300);
    rst_n = 1;
    tick(1);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      string tag;
      v = VEC[i];
      {en, supply_ok, soft_start, ocp_slow, ocp_fast, ov_rel, ov_abs, uv} = v[20:13];
      tick(int'(v[12:5]));
      tag = $sformatf("R%0d", v[24:21]);
      chk(tag, $sformatf("row %0d pwm_off", i), pwm_off, v[4]);
      chk(tag, $sformatf("row %0d rdy", i), rdy, v[3]);
      chk(tag, $sformatf("row %0d dac_ramp_dn", i), dac_ramp_dn, v[2]);
      chk(tag, $sformatf("row %0d code", i), fault_code, v[1:0]);
    end

    // R2 and R6 exact edges
    reenable();
    ocp_slow = 1;
    tick(TS - 1);
    chk("R2", "slow one edge early", pwm_off, 0);
    tick(1);
    chk("R2", "slow at expiry", pwm_off, 1);
    tick(TR - 1);
    chk("R6", "ready one edge early", rdy, 1);
    tick(1);
    chk("R6", "ready at expiry", rdy, 0);

    // R3 exact edges
    reenable();
    ocp_fast = 1;
    tick(TF - 1);
    chk("R3", "fast one edge early", pwm_off, 0);
    tick(1);
    chk("R3", "fast at expiry", pwm_off, 1);

    // R5 one-edge reaction
    reenable();
    ov_rel = 1;
    tick(1);
    chk("R5", "ovp next edge", pwm_off, 1);
    chk("R5", "ramp down", dac_ramp_dn, 1);
    ov_rel = 0;
    tick(3);
    chk("R7", "held after flag clears", pwm_off, 1);

    // R8 exact edges
    reenable();
    uv = 1;
    tick(TU - 1);
    chk("R8", "uv one edge early", rdy, 1);
    tick(1);
    chk("R8", "uv at expiry", rdy, 0);
    chk("R8", "uv leaves pwm", pwm_off, 0);
    uv = 0;
    tick(1);
    chk("R8", "uv release", rdy, 1);

    // R11
    low_power = 0; #1;
    chk("R11", "full power divider", ilim_div, 1);
    low_power = 1; phase_cnt = 3'd3; #1;
    chk("R11", "low power divider", ilim_div, 3);

    // R12
    uvm_din = 10'd123; uvm_we = 1;
    tick(1);
    uvm_we = 0; uvm_din = 10'd7;
    tick(1);
    chk("R12", "margin written", uv_margin, 123);
    reenable();
    chk("R12", "margin kept over enable cycle", uv_margin, 123);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule